// File: doc/BRIEF.md
# UART with per-entry tagged receive queue

This block is a full-duplex asynchronous serial port. The transmitter takes one character from a holding register and shifts it out on `txd`. Each frame has a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The receiver watches `rxd` and recovers characters of the same format. It places each one in a small receive queue, and every queue entry holds its own parity-error and framing-error tags next to the data. The tags presented with the head of the queue always describe the character that can be read at that moment.

A single divisor input sets the bit rate. An internal tick fires once every `divisor+1` clock cycles, and one bit lasts 16 ticks. The receiver uses these ticks as 16x oversampling and samples each bit at its middle. Static configuration inputs select the character format, the stop bit count, the fill level at which the receive interrupt is raised, and whether the transmit interrupt means "holding register free" or "everything has left the line". An error pulse is produced for every received character that carries an error. When a character completes while the queue is full, that character is discarded and an overrun flag is set.

Top module: `uart_tagq`

## Requirements
- R1: After reset `txd` is 1, `trmt` is 1, `tx_ready` is 1, `rx_valid` is 0, `rx_ovf` is 0, `rx_irq` is 0 and `err_irq` is 0.
- R2: A transmitted frame is a 0 start bit, then the data bits least significant first, then parity if it is enabled, then the stop bits at 1. Every bit is held for 16*(divisor+1) clock cycles, and the line rests at 1 between frames.
- R3: When `fmt[1]`=1 the frame carries 9 data bits and no parity. When `fmt[1]`=0 it carries 8 data bits, and `fmt[0]`=1 adds a parity bit. That parity is even when `par_odd`=0 (the parity bit makes the count of ones over data plus parity even) and odd when `par_odd`=1. Received 8-bit data appears on `rx_data[7:0]` with `rx_data[8]`=0.
- R4: A correctly framed received character enters the queue and shows on `rx_data` with `rx_valid`=1. A one-cycle `rx_rd` removes the head, and the queue holds up to DEPTH characters in arrival order.
- R5: Each queue entry keeps its own `rx_perr` (the parity did not match) and `rx_ferr` (the checked stop bit was 0). The tags are correct for every entry, including when all DEPTH entries carry errors.
- R6: When `stop2`=0 one stop bit is sent and checked. When `stop2`=1 two stop bits are sent, and the framing check uses only the second one: a frame whose first stop bit is 0 and whose second is 1 is not a framing error, and the reverse frame is.
- R7: A character that completes while the queue is full is dropped and sets `rx_ovf`. A read that removes an entry clears `rx_ovf`, and the entries already in the queue are unchanged.
- R8: `rx_irq` is set as follows. With `rx_lvl`=00 it is 1 when the queue holds at least one entry. With `rx_lvl`=01 it is 1 at DEPTH/2 or more entries. With `rx_lvl`=1x it is 1 at 3*DEPTH/4 or more entries, that is three-quarters full or full.
- R9: With `tx_mode`=0, `tx_irq` is 1 whenever the holding register is free. With `tx_mode`=1 it is 1 only once the holding register is free and the final stop bit of the last character has been shifted out.
- R10: `trmt` is 0 while a frame is being shifted out and becomes 1 once the last stop bit has been sent.
- R11: `err_irq` gives one single-cycle pulse for each received character that has a parity or framing error. This holds for characters that arrive back to back and for a character dropped by overrun.
- R12: A low level on `rxd` that is no longer low at the middle of the start bit (8 ticks after the falling edge) is rejected, and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Tick period minus one, in clock cycles |
| fmt | input | 2 | Character format: bit 1 selects 9-bit data, bit 0 enables parity in 8-bit mode |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| stop2 | input | 1 | 1 selects two stop bits |
| rx_lvl | input | 2 | Receive interrupt fill level |
| tx_mode | input | 1 | Transmit interrupt mode |
| tx_data | input | 9 | Character to transmit |
| tx_wr | input | 1 | Write strobe for tx_data, taken when tx_ready is 1 |
| tx_ready | output | 1 | Holding register free |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 9 | Data at the queue head |
| rx_perr | output | 1 | Parity-error tag of the head entry |
| rx_ferr | output | 1 | Framing-error tag of the head entry |
| rx_valid | output | 1 | Queue not empty |
| rx_rd | input | 1 | Remove the head entry |
| rx_ovf | output | 1 | Overrun flag |
| trmt | output | 1 | Transmit shift register empty |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| err_irq | output | 1 | Receive error pulse |

## Verification
The bench builds the block with its default parameters: a 4-entry queue and a 16-bit divisor. It drives divisor=1, so one bit lasts 32 clock cycles. A 4-entry queue reaches its three-quarters level, its full level and overrun within five received characters. That makes it possible to check, in one short run, that the tags stay correct on every entry when every queued character is erroneous. The short bit time keeps each of the tested formats (8-bit without parity, even, odd, 9-bit, one and two stop bits) down to a few hundred cycles per frame, in both directions.

// File: rtl/uart_tagq.sv
module uart_tagq #(
  parameter int DIV_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       fmt,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic [1:0]       rx_lvl,
  input  logic             tx_mode,
  input  logic [8:0]       tx_data,
  input  logic             tx_wr,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [8:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_valid,
  input  logic             rx_rd,
  output logic             rx_ovf,
  output logic             trmt,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             err_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int TQ = (3 * DEPTH) / 4;
  localparam int HF = DEPTH / 2;

  logic [DIV_W-1:0] dcnt;
  wire tick  = (dcnt == divisor);
  wire nine  = fmt[1];
  wire paren = !fmt[1] && fmt[0];
  wire [3:0] nfr = 4'd10 + {3'b0, nine} + {3'b0, paren} + {3'b0, stop2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dcnt + 1'b1;

  logic [8:0]  hold;
  logic        hold_v, tbusy;
  logic [11:0] tsh, tfr;
  logic [3:0]  tleft, tsub;

  always_comb begin
    tfr    = '1;
    tfr[0] = 1'b0;
    if (nine) tfr[9:1] = hold;
    else begin
      tfr[8:1] = hold[7:0];
      if (paren) tfr[9] = ^hold[7:0] ^ par_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_v <= 1'b0; tbusy <= 1'b0;
      tsh <= '1; tleft <= '0; tsub <= '0;
    end else begin
      if (tx_wr && !hold_v) begin
        hold   <= tx_data;
        hold_v <= 1'b1;
      end
      if (!tbusy && hold_v) begin
        tsh    <= tfr;
        tleft  <= nfr;
        tsub   <= '0;
        tbusy  <= 1'b1;
        hold_v <= 1'b0;
      end else if (tbusy && tick) begin
        tsub <= tsub + 1'b1;
        if (tsub == 4'd15) begin
          tsh   <= {1'b1, tsh[11:1]};
          tleft <= tleft - 1'b1;
          if (tleft == 4'd1) tbusy <= 1'b0;
        end
      end
    end

  assign txd      = tsh[0];
  assign trmt     = !tbusy;
  assign tx_ready = !hold_v;
  assign tx_irq   = tx_mode ? (!tbusy && !hold_v) : !hold_v;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_WAIT} rx_st_e;
  rx_st_e      rstate;
  logic [1:0]  rs;
  logic [3:0]  rsub, ridx;
  logic [11:0] rbits;
  logic        done;
  wire         rin = rs[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs <= 2'b11; rstate <= R_IDLE; rsub <= '0; ridx <= '0;
      rbits <= '0; done <= 1'b0;
    end else begin
      rs   <= {rs[0], rxd};
      done <= 1'b0;
      case (rstate)
        R_IDLE: if (!rin) begin
          rstate <= R_START;
          rsub   <= '0;
        end
        R_START: if (tick) begin
          rsub <= rsub + 1'b1;
          if (rsub == 4'd7) begin
            if (!rin) begin
              rstate <= R_BITS;
              rsub   <= '0;
              ridx   <= '0;
            end else rstate <= R_IDLE;
          end
        end
        R_BITS: if (tick) begin
          rsub <= rsub + 1'b1;
          if (rsub == 4'd15) begin
            rbits[ridx] <= rin;
            ridx <= ridx + 1'b1;
            if (ridx == nfr - 4'd2) begin
              done   <= 1'b1;
              rstate <= rin ? R_IDLE : R_WAIT;
            end
          end
        end
        default: if (rin) rstate <= R_IDLE;
      endcase
    end

  wire       fr_ferr = !rbits[nfr - 4'd2];
  wire       fr_perr = paren && ((^rbits[8:0]) != par_odd);
  wire [8:0] fr_data = nine ? rbits[8:0] : {1'b0, rbits[7:0]};

  logic [10:0] mem [DEPTH];
  logic [AW:0] wp, rp;
  wire  [AW:0] cnt   = wp - rp;
  wire         full  = (cnt == (AW+1)'(DEPTH));
  wire         empty = (cnt == '0);
  wire         pop   = rx_rd && !empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; rx_ovf <= 1'b0; err_irq <= 1'b0;
    end else begin
      err_irq <= done && (fr_perr || fr_ferr);
      if (done && !full) begin
        mem[wp[AW-1:0]] <= {fr_ferr, fr_perr, fr_data};
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      if (done && full) rx_ovf <= 1'b1;
      else if (pop)     rx_ovf <= 1'b0;
    end

  assign {rx_ferr, rx_perr, rx_data} = mem[rp[AW-1:0]];
  assign rx_valid = !empty;
  assign rx_irq   = rx_lvl[1] ? (int'(cnt) >= TQ) :
                    rx_lvl[0] ? (int'(cnt) >= HF) : !empty;
endmodule

module uart_tagq_chk #(
  parameter int DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [$clog2(DEPTH):0] cnt,
  input logic              full,
  input logic              txd,
  input logic              trmt,
  input logic              rx_ovf,
  input logic              rx_irq,
  input logic              rx_valid,
  input logic              tx_irq,
  input logic              tx_mode,
  input logic              err_irq
);
  assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trmt |-> txd);
  assert_ovf_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(full));
  assert_txirq_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && tx_irq) |-> trmt);
  assert_rxirq_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);
  assert_err_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
endmodule

bind uart_tagq uart_tagq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .full(full), .txd(txd), .trmt(trmt),
  .rx_ovf(rx_ovf), .rx_irq(rx_irq), .rx_valid(rx_valid), .tx_irq(tx_irq),
  .tx_mode(tx_mode), .err_irq(err_irq)
);

// File: tb/uart_tagq_bench.sv
`timescale 1ns/1ps
module uart_tagq_bench;
  localparam int BIT = 32;

  logic clk = 0, rst_n = 0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] fmt = 2'b00, rx_lvl = 2'b00;
  logic par_odd = 0, stop2 = 0, tx_mode = 0, tx_wr = 0, rx_rd = 0, rxd = 1;
  logic [8:0] tx_data = '0;
  logic tx_ready, txd, rx_perr, rx_ferr, rx_valid, rx_ovf, trmt, rx_irq, tx_irq, err_irq;
  logic [8:0] rx_data;
  int nchk = 0, nerr = 0, errpulses = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_tagq u_uart_tagq (
    .clk, .rst_n, .divisor, .fmt, .par_odd, .stop2, .rx_lvl, .tx_mode,
    .tx_data, .tx_wr, .tx_ready, .txd, .rxd, .rx_data, .rx_perr, .rx_ferr,
    .rx_valid, .rx_rd, .rx_ovf, .trmt, .rx_irq, .tx_irq, .err_irq
  );

  always @(posedge clk) if (rst_n && err_irq) errpulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] frame(input logic [8:0] d, input bit nine, input bit pe,
      input bit odd, input bit flip, input bit s1, input bit s2, input bit two, output int n);
    logic [11:0] b;
    int k;
    b = '1; b[0] = 1'b0; k = 1;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin b[k] = d[i]; k++; end
    if (pe && !nine) begin b[k] = ^d[7:0] ^ odd ^ flip; k++; end
    b[k] = s1; k++;
    if (two) begin b[k] = s2; k++; end
    n = k;
    return b;
  endfunction

  task automatic send_rx(input logic [8:0] d, input bit flip, input bit s1, input bit s2);
    int n;
    logic [11:0] b;
    b = frame(d, fmt[1], fmt[0], par_odd, flip, s1, s2, stop2, n);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic head(input string req, input logic [8:0] d, input bit pe, input bit fe);
    chk({req, " data"}, rx_data, d);
    chk({req, " perr"}, rx_perr, pe);
    chk({req, " ferr"}, rx_ferr, fe);
    pop();
  endtask

  task automatic tx_one(input string req, input logic [8:0] d);
    int n, w;
    logic [11:0] exp;
    exp = frame(d, fmt[1], fmt[0], par_odd, 0, 1, 1, stop2, n);
    @(negedge clk); tx_data = d; tx_wr = 1; @(negedge clk); tx_wr = 0;
    w = 0;
    while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
    repeat (BIT/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk({req, " bit"}, txd, exp[i]);
      if (i == 1) begin
        chk("R10 trmt low mid-frame", trmt, 0);
        chk("R9 tx_irq mid-frame", tx_irq, !tx_mode);
      end
      repeat (BIT) @(negedge clk);
    end
    chk("R10 trmt after frame", trmt, 1);
    chk("R9 tx_irq after frame", tx_irq, 1);
  endtask

  task automatic t_reset();
    chk("R1 txd", txd, 1); chk("R1 trmt", trmt, 1); chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 rx_ovf", rx_ovf, 0);
    chk("R1 rx_irq", rx_irq, 0); chk("R1 err_irq", err_irq, 0);
  endtask

  task automatic t_tx();
    fmt = 2'b00; stop2 = 0; tx_mode = 1; tx_one("R2 8N1", 9'h0A5);
    fmt = 2'b01; par_odd = 0; tx_mode = 0; tx_one("R3 even parity", 9'h007);
    par_odd = 1; tx_one("R3 odd parity", 9'h007);
    fmt = 2'b10; stop2 = 1; tx_mode = 1; tx_one("R2 R3 9-bit two stop", 9'h1A5);
    stop2 = 0;
  endtask

  task automatic t_rx_basic();
    fmt = 2'b00; rx_lvl = 2'b00;
    send_rx(9'h03C, 0, 1, 1);
    chk("R4 valid", rx_valid, 1); chk("R8 level 00", rx_irq, 1);
    head("R4 basic", 9'h03C, 0, 0);
    chk("R4 empty after read", rx_valid, 0);
    fmt = 2'b10;
    send_rx(9'h155, 0, 1, 1);
    head("R3 9-bit receive", 9'h155, 0, 0);
  endtask

  task automatic t_tags();
    fmt = 2'b01; par_odd = 0; rx_lvl = 2'b10; errpulses = 0;
    send_rx(9'h011, 1, 1, 1);
    send_rx(9'h022, 0, 0, 1);
    chk("R8 level 1x at 2", rx_irq, 0);
    rx_lvl = 2'b01; @(negedge clk);
    chk("R8 level 01 at 2", rx_irq, 1);
    rx_lvl = 2'b10;
    send_rx(9'h033, 1, 1, 1);
    chk("R8 level 1x at 3", rx_irq, 1);
    send_rx(9'h044, 1, 0, 1);
    chk("R7 no ovf at full", rx_ovf, 0);
    send_rx(9'h055, 0, 1, 1);
    chk("R7 ovf set", rx_ovf, 1);
    chk("R11 error pulses", errpulses, 4);
    head("R5 entry0", 9'h011, 1, 0);
    chk("R7 ovf cleared by read", rx_ovf, 0);
    head("R5 entry1", 9'h022, 0, 1);
    head("R5 entry2", 9'h033, 1, 0);
    head("R5 entry3", 9'h044, 1, 1);
    chk("R7 dropped byte absent", rx_valid, 0);
  endtask

  task automatic t_stop2();
    fmt = 2'b00; stop2 = 1;
    send_rx(9'h0C3, 0, 0, 1);
    head("R6 first stop low", 9'h0C3, 0, 0);
    send_rx(9'h03C, 0, 1, 0);
    head("R6 second stop low", 9'h03C, 0, 1);
    stop2 = 0;
  endtask

  task automatic t_glitch();
    fmt = 2'b00;
    rxd = 0; repeat (6) @(negedge clk); rxd = 1;
    repeat (BIT*14) @(negedge clk);
    chk("R12 glitch rejected", rx_valid, 0);
    send_rx(9'h05A, 0, 1, 1);
    head("R12 receive after glitch", 9'h05A, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx_basic();
    t_tags();
    t_stop2();
    t_glitch();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule